// File: doc/BRIEF.md
# Token-list I2C bus master

This block is an I2C bus master that a host drives by loading a short program rather than by issuing one command per byte. The host writes up to sixteen 4-bit tokens into two list words, up to eight outgoing bytes into two write-data words, and a target address, then arms the run with a rising edge of the start bit in the control word. The sequencer then steps through the tokens in order: start condition, address with write or read direction, data byte, final data byte, stop condition, and end. Bytes that are received are stored in two read-data words.

When the run reaches an end token, uses up all sixteen slots, or stops on a missing acknowledge, the block raises a one-cycle interrupt and drops its busy flag. A list may finish without a stop token. The bus is then left held with SCL low, and a second list can carry on with the same message. The bus lines are open-drain: each line is driven low through an enable output, and SDA is read back through an input. Bus timing comes from a 12-bit divider that produces quarter-bit ticks.

Top module: `i2c_tok_master`

## Requirements
- R1: After reset, the control word (offset 0x00) and the read-data words read 0, both line enables (scl_oe, sda_oe) are 0, and irq is 0.
- R2: A run begins only when a write to offset 0x00 takes control bit 0 from 0 to 1. Writing 1 again while the bit is already 1 starts no bus activity and leaves busy (bit 2) at 0.
- R3: Token n is held in bits [4n+3:4n] of list word 0 (offset 0x08) for n<8, and in list word 1 (offset 0x0C) for n≥8. The codes are 0 end, 1 start, 2 address+write, 3 address+read, 4 data, 5 last data, 6 stop. An address token sends target-address register bits [7:1] (offset 0x04) followed by R/W = 0 for write or 1 for read. Write data tokens send, MSB first, the next byte from the little-endian window formed by write words 0x10 (bytes 0..3) and 0x14 (bytes 4..7).
- R4: In read direction, a data token acknowledges the received byte (SDA low) and a last-data token answers with NACK (SDA high). Received bytes are stored little-endian into words 0x18 and 0x1C. These words are cleared when a run begins.
- R5: When ack-ignore (bit 1) is 0 and a transmitted byte is not acknowledged, error (bit 3) is set, a stop condition is issued without a token, irq pulses, busy clears and no later token runs.
- R6: When ack-ignore is 1, a missing acknowledge sets no error and the list continues.
- R7: irq pulses for one cycle and busy clears when an end token is reached or after the sixteenth slot has run.
- R8: The divider occupies bits [21:12] (low 10 bits) and [29:28] (high 2 bits) of the control word and reads back there. SCL stays high for 2×divider clock cycles in each bit, so a full SCL period is 4×divider cycles.
- R9: Inside a byte, SDA changes only while SCL is low. SDA moves while SCL is high only for start and stop conditions.
- R10: A list with no stop token leaves SCL held low. The next run continues the message, and its byte index restarts at byte 0.
- R11: Writing control bit 0 as 0 during a run clears busy. No further token is started and no irq is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 5 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | One-cycle completion/error pulse |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
The hardest behaviour to reach from the ports is a run that spans more than one list. A first list has to leave SCL held low in the middle of a message, and a second run then has to carry on from that state with its byte index back at zero. The bench reaches this by loading a list that ends after one data byte without a stop, checking the held clock, and then re-arming with a list that holds only data and stop tokens. A behavioural target on the bus watches every clock edge: it acknowledges or refuses addresses and serves read bytes, and it logs each byte and each master acknowledge. Separate runs fill all sixteen slots with no end token, refuse the address with ack-ignore off and with it on, and abort a run while its start condition is still being sent.

// File: rtl/i2c_tok_pkg.sv
package i2c_tok_pkg;
    localparam int DIV_W = 12;

    typedef enum logic [3:0] {
        TK_END     = 4'd0,
        TK_START   = 4'd1,
        TK_ADDR_WR = 4'd2,
        TK_ADDR_RD = 4'd3,
        TK_DATA    = 4'd4,
        TK_LAST    = 4'd5,
        TK_STOP    = 4'd6
    } tok_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;
endpackage

// File: rtl/i2c_tok_tick.sv
module i2c_tok_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } st_t;

    st_t s_q, s_d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim = (div == '0) ? DIV_W'(1) : div;
        s_d = s_q;
        s_d.tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= lim - DIV_W'(1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    // R8: with a divider above one, quarter ticks never come back to back
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tick && div > DIV_W'(1) && $stable(div)) |=> !s_q.tick);
endmodule

// File: rtl/i2c_tok_bus.sv
module i2c_tok_bus
    import i2c_tok_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  op_e        cmd_op,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_nack,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       acked,
    output logic       scl_oe,
    output logic       sda_oe
);
    typedef struct packed {
        logic       busy;
        op_e        op;
        logic [1:0] q;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       nack;
        logic       scl_oe;
        logic       sda_oe;
        logic       acked;
        logic       done;
    } st_t;

    st_t  s_q, s_d;
    logic ack_bit, rd;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        ack_bit  = (s_q.bitn == 4'd8);
        rd       = (s_q.op == OP_READ);
        if (!s_q.busy) begin
            if (cmd_valid) begin
                s_d.busy = 1'b1;
                s_d.op   = cmd_op;
                s_d.q    = 2'd0;
                s_d.bitn = 4'd0;
                s_d.sh   = cmd_byte;
                s_d.nack = cmd_nack;
            end
        end else if (tick) begin
            s_d.q = s_q.q + 2'd1;
            case (s_q.op)
                OP_START: begin
                    case (s_q.q)
                        2'd0: s_d.sda_oe = 1'b0;
                        2'd1: s_d.scl_oe = 1'b0;
                        2'd2: s_d.sda_oe = 1'b1;
                        default: begin
                            s_d.scl_oe = 1'b1;
                            s_d.busy   = 1'b0;
                            s_d.done   = 1'b1;
                        end
                    endcase
                end
                OP_STOP: begin
                    case (s_q.q)
                        2'd0: s_d.sda_oe = 1'b1;
                        2'd1: s_d.scl_oe = 1'b0;
                        2'd2: s_d.sda_oe = 1'b0;
                        default: begin
                            s_d.busy = 1'b0;
                            s_d.done = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (s_q.q)
                        2'd0: s_d.sda_oe = ack_bit ? (rd ? !s_q.nack : 1'b0)
                                                   : (rd ? 1'b0 : !s_q.sh[7]);
                        2'd1: s_d.scl_oe = 1'b0;
                        2'd2: begin
                            if (!ack_bit) s_d.sh = {s_q.sh[6:0], rd ? sda_in : 1'b0};
                            else          s_d.acked = !sda_in;
                        end
                        default: begin
                            s_d.scl_oe = 1'b1;
                            if (ack_bit) begin
                                s_d.busy = 1'b0;
                                s_d.done = 1'b1;
                            end else begin
                                s_d.bitn = s_q.bitn + 4'd1;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rx_byte = s_q.sh;
    assign acked   = s_q.acked;
    assign scl_oe  = s_q.scl_oe;
    assign sda_oe  = s_q.sda_oe;

    // R9: an SDA move while SCL stays released belongs to a start or stop primitive
    p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.sda_oe) && !s_q.scl_oe && !$past(s_q.scl_oe))
        |-> (s_q.op == OP_START || s_q.op == OP_STOP));

    // R7: completion of a primitive is a single-cycle event
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
endmodule

// File: rtl/i2c_tok_master.sv
module i2c_tok_master
    import i2c_tok_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [4:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    localparam int WORD_W = 32;
    localparam int WIN_W  = 2 * WORD_W;
    localparam int SLOTS  = WIN_W / 4;
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int BYTES  = WIN_W / 8;
    localparam int BIDX_W = $clog2(BYTES);

    typedef struct packed {
        logic              start;
        logic              ackign;
        logic              err;
        logic              busy;
        logic [DIV_W-1:0]  div;
        logic [7:0]        taddr;
        logic [WIN_W-1:0]  list;
        logic [WIN_W-1:0]  wdat;
        logic [WIN_W-1:0]  rdat;
        logic [IDX_W-1:0]  idx;
        logic [BIDX_W-1:0] bidx;
        logic              pend;
        logic              stopping;
        logic              dir_rd;
        logic              is_data;
        op_e               cur_op;
        logic              irq;
    } st_t;

    st_t        s_q, s_d;
    logic       tick, eng_busy, eng_done, eng_acked;
    logic [7:0] eng_rx;
    logic       cmd_valid, cmd_nack;
    op_e        cmd_op;
    logic [7:0] cmd_byte;
    logic [3:0] tok;
    logic [7:0] wbyte;
    logic       iss, iss_data, fin;

    i2c_tok_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(s_q.div), .tick(tick)
    );

    i2c_tok_bus u_bus (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
        .sda_in(sda_in), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .acked(eng_acked), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        tok       = s_q.list[{s_q.idx, 2'b00} +: 4];
        wbyte     = s_q.wdat[{s_q.bidx, 3'b000} +: 8];
        iss       = 1'b0;
        iss_data  = 1'b0;
        fin       = 1'b0;
        cmd_op    = OP_START;
        cmd_byte  = 8'h00;
        cmd_nack  = 1'b0;

        if (s_q.busy) begin
            if (s_q.pend) begin
                if (eng_done) begin
                    s_d.pend = 1'b0;
                    if (s_q.stopping) begin
                        fin = 1'b1;
                    end else begin
                        if (s_q.is_data) begin
                            if (s_q.cur_op == OP_READ)
                                s_d.rdat[{s_q.bidx, 3'b000} +: 8] = eng_rx;
                            s_d.bidx = s_q.bidx + BIDX_W'(1);
                        end
                        if (s_q.cur_op == OP_WRITE && !eng_acked && !s_q.ackign) begin
                            s_d.err      = 1'b1;
                            s_d.stopping = 1'b1;
                        end else if (s_q.idx == IDX_W'(SLOTS - 1)) begin
                            fin = 1'b1;
                        end else begin
                            s_d.idx = s_q.idx + IDX_W'(1);
                        end
                    end
                end
            end else if (!eng_busy) begin
                if (s_q.stopping) begin
                    iss    = 1'b1;
                    cmd_op = OP_STOP;
                end else begin
                    case (tok)
                        TK_START: begin iss = 1'b1; cmd_op = OP_START; end
                        TK_STOP:  begin iss = 1'b1; cmd_op = OP_STOP;  end
                        TK_ADDR_WR, TK_ADDR_RD: begin
                            iss        = 1'b1;
                            cmd_op     = OP_WRITE;
                            cmd_byte   = {s_q.taddr[7:1], tok == TK_ADDR_RD};
                            s_d.dir_rd = (tok == TK_ADDR_RD);
                        end
                        TK_DATA, TK_LAST: begin
                            iss      = 1'b1;
                            iss_data = 1'b1;
                            cmd_op   = s_q.dir_rd ? OP_READ : OP_WRITE;
                            cmd_byte = wbyte;
                            cmd_nack = (tok == TK_LAST);
                        end
                        default: fin = 1'b1;
                    endcase
                end
            end
        end

        cmd_valid = iss;
        if (iss) begin
            s_d.pend    = 1'b1;
            s_d.cur_op  = cmd_op;
            s_d.is_data = iss_data;
        end
        if (fin) begin
            s_d.busy = 1'b0;
            s_d.irq  = 1'b1;
        end

        if (reg_wr) begin
            case (reg_waddr)
                5'h00: begin
                    s_d.start  = reg_wdata[0];
                    s_d.ackign = reg_wdata[1];
                    s_d.div    = {reg_wdata[29:28], reg_wdata[21:12]};
                    if (reg_wdata[0] && !s_q.start) begin
                        s_d.busy     = 1'b1;
                        s_d.idx      = '0;
                        s_d.bidx     = '0;
                        s_d.rdat     = '0;
                        s_d.err      = 1'b0;
                        s_d.pend     = 1'b0;
                        s_d.stopping = 1'b0;
                    end else if (!reg_wdata[0]) begin
                        s_d.busy = 1'b0;
                        s_d.irq  = 1'b0;
                    end
                end
                5'h04: s_d.taddr               = reg_wdata[7:0];
                5'h08: s_d.list[WORD_W-1:0]     = reg_wdata;
                5'h0C: s_d.list[WIN_W-1:WORD_W] = reg_wdata;
                5'h10: s_d.wdat[WORD_W-1:0]     = reg_wdata;
                5'h14: s_d.wdat[WIN_W-1:WORD_W] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_raddr)
            5'h00: reg_rdata = {2'b00, s_q.div[11:10], 6'd0, s_q.div[9:0], 8'd0,
                                s_q.err, s_q.busy, s_q.ackign, s_q.start};
            5'h04: reg_rdata = {24'd0, s_q.taddr};
            5'h08: reg_rdata = s_q.list[WORD_W-1:0];
            5'h0C: reg_rdata = s_q.list[WIN_W-1:WORD_W];
            5'h10: reg_rdata = s_q.wdat[WORD_W-1:0];
            5'h14: reg_rdata = s_q.wdat[WIN_W-1:WORD_W];
            5'h18: reg_rdata = s_q.rdat[WORD_W-1:0];
            5'h1C: reg_rdata = s_q.rdat[WIN_W-1:WORD_W];
            default: reg_rdata = '0;
        endcase
    end

    assign irq = s_q.irq;

    // R4: a fresh run starts with an empty read window and no error
    p_launch_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> (s_q.rdat == '0 && !s_q.err));

    // R5: error only appears while acknowledges were being enforced
    p_err_needs_enforce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.err) |-> !$past(s_q.ackign));

    // R7: an interrupt only closes a run that was in progress
    p_irq_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> ($past(s_q.busy) && !s_q.busy));

    // R3: the sequencer only hands a primitive to an idle bus engine
    p_issue_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> eng_busy);
endmodule

// File: tb/i2c_tok_master_tb.sv
module i2c_tok_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq, scl_oe, sda_oe;
    logic        tgt_low = 1'b0;
    logic        scl, sda;

    assign scl = !scl_oe;
    assign sda = !(sda_oe || tgt_low);

    i2c_tok_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
    );

    always #2 clk = !clk;

    localparam logic [6:0] TADDR = 7'h50;

    int checks = 0, failures = 0;
    bit finished = 0;
    int cur_div = 3;

    // behavioural target and bus monitor state
    int   byte_log[$];
    int   mack_log[$];
    int   rdq[$];
    int   n_start = 0, n_stop = 0, viol = 0, hi_bad = 0, hi_checked = 0, irq_cnt = 0;
    int   bitcnt = 0, hi_len = 0;
    bit   prev_scl = 1, prev_sda = 1, rose = 0, after_ack = 0;
    bit   addr_ph = 0, matched = 0, rd_req = 0, rd_cur = 0, last_mack = 1;
    logic [7:0] sh = 0, txb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            tgt_low <= 1'b0;
            prev_scl = 1; prev_sda = 1;
        end else begin
            if (irq) irq_cnt++;
            if (scl && prev_scl) hi_len++;
            if (scl && prev_scl && prev_sda && !sda) begin
                n_start++;
                if (bitcnt >= 2) viol++;
                bitcnt = 0; addr_ph = 1; rd_cur = 0; matched = 0; after_ack = 0;
                tgt_low <= 1'b0;
            end else if (scl && prev_scl && !prev_sda && sda) begin
                n_stop++;
                if (bitcnt >= 2) viol++;
                bitcnt = 0; rd_cur = 0; rose = 0; after_ack = 0;
                tgt_low <= 1'b0;
            end else if (scl && !prev_scl) begin
                hi_len = 1; rose = 1;
                if (bitcnt < 8) sh = {sh[6:0], sda};
                else if (rd_cur) begin mack_log.push_back(int'(sda)); last_mack = sda; end
                after_ack = (bitcnt == 8);
                bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
            end else if (!scl && prev_scl) begin
                if (rose) begin
                    hi_checked++;
                    if (hi_len != 2 * cur_div) hi_bad++;
                end
                rose = 0;
                if (bitcnt == 8) begin
                    if (rd_cur) tgt_low <= 1'b0;
                    else begin
                        byte_log.push_back(int'(sh));
                        if (addr_ph) begin matched = (sh[7:1] == TADDR); rd_req = sh[0]; end
                        tgt_low <= matched;
                    end
                end else if (bitcnt == 0 && after_ack) begin
                    after_ack = 0;
                    if ((addr_ph && matched && rd_req) || (!addr_ph && rd_cur && !last_mack)) begin
                        txb = (rdq.size() > 0) ? 8'(rdq.pop_front()) : 8'hFF;
                        rd_cur = 1;
                        tgt_low <= !txb[7];
                    end else begin
                        rd_cur = 0;
                        tgt_low <= 1'b0;
                    end
                    addr_ph = 0;
                end else if (rd_cur && bitcnt >= 1 && bitcnt <= 7) begin
                    tgt_low <= !txb[7 - bitcnt];
                end
            end
            prev_scl = scl; prev_sda = sda;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit st, input bit ign, input int dv);
        logic [11:0] d12 = 12'(dv);
        return (32'(d12[11:10]) << 28) | (32'(d12[9:0]) << 12) | (32'(ign) << 1) | 32'(st);
    endfunction

    task automatic launch(input bit ign);
        wr(5'h00, ctl(0, ign, cur_div));
        wr(5'h00, ctl(1, ign, cur_div));
    endtask

    task automatic wait_irq(input int base, input string req);
        int n = 0;
        while (irq_cnt == base && n < 20000) begin @(negedge clk); n++; end
        check(irq_cnt == base + 1, req, irq_cnt, base + 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_log(input int exp[$], input string req);
        check(byte_log.size() == exp.size(), req, byte_log.size(), exp.size());
        for (int i = 0; i < exp.size() && i < byte_log.size(); i++)
            check(byte_log[i] == exp[i], req, byte_log[i], exp[i]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int base, s0, p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); check(v == 0, "R1 ctrl", v, 0);
        rd(5'h18, v); check(v == 0, "R1 rdata0", v, 0);
        check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        check(!irq, "R1 irq", irq, 0);

        // R8 divider field placement
        wr(5'h00, ctl(0, 0, 12'hC05));
        rd(5'h00, v); check(v == 32'h3000_5000, "R8 divider readback", v, 32'h3000_5000);

        // R3 write message: S AW D D D P E
        cur_div = 3;
        wr(5'h04, {24'd0, TADDR, 1'b0});
        wr(5'h08, 32'h0064_4421); wr(5'h0C, 0);
        wr(5'h10, 32'h0033_2211);
        byte_log.delete(); base = irq_cnt; s0 = n_start; p0 = n_stop;
        launch(0);
        rd(5'h00, v); check(v[2], "R2 busy after rising start", v[2], 1);
        wait_irq(base, "R7 irq on end token");
        check_log('{8'hA0, 8'h11, 8'h22, 8'h33}, "R3 write bytes");
        check(n_start == s0 + 1 && n_stop == p0 + 1, "R3 one start one stop",
              (n_start - s0) * 16 + (n_stop - p0), 17);
        rd(5'h00, v); check(v[3:2] == 0, "R7 busy and error clear", v[3:2], 0);

        // R2 rewriting start=1 does nothing
        base = irq_cnt; s0 = n_start;
        wr(5'h00, ctl(1, 0, cur_div));
        repeat (200) @(negedge clk);
        rd(5'h00, v); check(v[2] == 0, "R2 no relaunch busy", v[2], 0);
        check(n_start == s0 && irq_cnt == base, "R2 no relaunch bus", n_start - s0, 0);

        // R4 read message: S AR D D L P
        byte_log.delete(); mack_log.delete();
        rdq = '{8'hA5, 8'h5A, 8'hC3};
        wr(5'h08, 32'h0065_4431);
        base = irq_cnt; launch(0);
        wait_irq(base, "R4 read irq");
        rd(5'h18, v); check(v == 32'h00C3_5AA5, "R4 read packing", v, 32'h00C3_5AA5);
        check(mack_log.size() == 3, "R4 ack count", mack_log.size(), 3);
        if (mack_log.size() == 3)
            check(mack_log[0] == 0 && mack_log[1] == 0 && mack_log[2] == 1, "R4 ack then nack",
                  mack_log[0] * 4 + mack_log[1] * 2 + mack_log[2], 1);
        check_log('{8'hA1}, "R4 read address byte");

        // R4 read window cleared on a new run
        rdq = '{8'h7E};
        wr(5'h08, 32'h0000_6531);
        base = irq_cnt; launch(0);
        wait_irq(base, "R4 second read irq");
        rd(5'h18, v); check(v == 32'h0000_007E, "R4 window cleared", v, 32'h7E);

        // R5 refused address with enforcement
        byte_log.delete();
        wr(5'h04, 32'h66);
        wr(5'h08, 32'h0000_6421);
        wr(5'h10, 32'h0000_0077);
        base = irq_cnt; p0 = n_stop; launch(0);
        wait_irq(base, "R5 irq on nack");
        rd(5'h00, v); check(v[3:2] == 2'b10, "R5 error set busy clear", v[3:2], 2);
        check_log('{8'h66}, "R5 no data after nack");
        check(n_stop == p0 + 1, "R5 automatic stop", n_stop - p0, 1);
        check(!scl_oe && !sda_oe, "R5 bus released", {scl_oe, sda_oe}, 0);

        // R6 same with ack-ignore, slower divider
        cur_div = 5;
        byte_log.delete();
        base = irq_cnt; launch(1);
        wait_irq(base, "R6 irq");
        rd(5'h00, v); check(v[3] == 0, "R6 no error", v[3], 0);
        check_log('{8'h66, 8'h77}, "R6 list continues");

        // R7 sixteen slots, no end token
        cur_div = 3;
        byte_log.delete();
        wr(5'h04, {24'd0, TADDR, 1'b0});
        wr(5'h08, 32'h1644_4421); wr(5'h0C, 32'h6164_4442);
        wr(5'h10, 32'h4433_2211); wr(5'h14, 32'h8877_6655);
        base = irq_cnt; s0 = n_start; p0 = n_stop; launch(0);
        wait_irq(base, "R7 irq after 16 slots");
        check_log('{8'hA0, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA0, 8'h55, 8'h66, 8'h77, 8'h88},
                  "R7 sixteen slot bytes");
        check(n_start == s0 + 3 && n_stop == p0 + 3, "R7 three frames",
              (n_start - s0) * 16 + (n_stop - p0), 51);
        rd(5'h00, v); check(v[2] == 0, "R7 busy clear", v[2], 0);

        // R10 continuation across lists
        byte_log.delete();
        wr(5'h0C, 0);
        wr(5'h08, 32'h0000_0421);
        wr(5'h10, 32'h0000_00AB);
        base = irq_cnt; s0 = n_start; p0 = n_stop; launch(0);
        wait_irq(base, "R10 first list irq");
        check(scl_oe == 1'b1, "R10 clock held low", scl_oe, 1);
        wr(5'h08, 32'h0000_0644);
        wr(5'h10, 32'h0000_CDEF);
        base = irq_cnt; launch(0);
        wait_irq(base, "R10 second list irq");
        check_log('{8'hA0, 8'hAB, 8'hEF, 8'hCD}, "R10 continued bytes");
        check(n_start == s0 + 1 && n_stop == p0 + 1, "R10 single frame",
              (n_start - s0) * 16 + (n_stop - p0), 17);

        // R11 abort during start condition
        byte_log.delete();
        wr(5'h08, 32'h0644_4421);
        base = irq_cnt; launch(0);
        repeat (3) @(negedge clk);
        wr(5'h00, ctl(0, 0, cur_div));
        repeat (600) @(negedge clk);
        rd(5'h00, v); check(v[2] == 0, "R11 busy clear", v[2], 0);
        check(irq_cnt == base, "R11 no irq", irq_cnt - base, 0);
        check(byte_log.size() == 0, "R11 no further token", byte_log.size(), 0);
        wr(5'h08, 32'h0000_0006);
        base = irq_cnt; launch(0);
        wait_irq(base, "R11 cleanup stop");
        check(!scl_oe && !sda_oe, "R11 bus released", {scl_oe, sda_oe}, 0);

        // R8 / R9 bus-wide observations
        check(hi_checked > 0 && hi_bad == 0, "R8 scl high time", hi_bad, 0);
        check(viol == 0, "R9 sda only moves with scl low", viol, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule